// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the network layer of a slave on a single-wire open-drain bus. It sits above a bit-slot engine that handles the analog timing. After the engine reports a bus reset, the layer takes in an 8-bit ROM command and carries it out against the device's 64-bit identity. Depending on the command, it then hands control to the device function layer or stays silent until the next reset.

Bits pass to and from the slot engine over two request/acknowledge handshakes:

- **Receive handshake:** the layer raises `rx_req_o`. The engine answers with `rx_ack_i` and the sampled `rx_bit_i`.
- **Send handshake:** the layer raises `tx_req_o` with `tx_bit_o`. The engine answers with `tx_ack_i` once the slot is done.

The layer keeps a resume flag, so a device that was addressed earlier can be reselected cheaply. It also keeps an overdrive flag, which the slot engine reads to switch to fast timing.

Top module: `sw_rom_layer`

## Requirements
- R1: After `rst_ni` is released, no request is raised and `od_o`, `rc_o` and `func_o` are all 0 until the first bus reset. A pulse on `bus_reset_i` in any state makes the layer request command bits from the next cycle.
- R2: A command is 8 received bits, least significant bit first. The recognised codes are 0x33 read-ID, 0x55 match, 0xF0 search, 0xCC skip, 0xA5 resume, 0x3C overdrive-skip and 0x69 overdrive-match. Receive and send requests are never raised together.
- R3: Read-ID sends all 64 bits of `dev_id_i`, bit 0 first, and then passes control to the function layer.
- R4: Match clears the resume flag. It then receives 64 bits and compares each with `dev_id_i`, bit 0 first. An exact match passes control and sets the resume flag. The first differing bit makes the layer idle until a bus reset: no request is raised and control is not passed.
- R5: Search handles each ID bit in three slots, bit 0 first: send the true bit, send its complement, then receive the master's bit. A differing received bit makes the layer idle. Completing all 64 bits passes control and sets the resume flag. Entering search clears the resume flag.
- R6: Skip passes control and leaves both the resume flag and the overdrive flag unchanged.
- R7: Resume passes control if the resume flag is set. Otherwise the layer goes idle.
- R8: Overdrive-skip sets `od_o` and passes control.
- R9: Overdrive-match sets `od_o` once the command byte is complete, then behaves as match in R4.
- R10: A bus reset with `long_reset_i` high clears `od_o`. A bus reset with `long_reset_i` low leaves `od_o` unchanged. No bus reset changes `rc_o`.
- R11: Any other command code makes the layer idle until a bus reset.
- R12: A bus reset that coincides with the acknowledge completing a command's final bit takes priority. No control is passed, the resume flag does not change, and the layer waits for a new command.
- R13: Passing control raises `func_go_o` for exactly one cycle. In that same cycle `func_o` rises, and it stays high until a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse: the slot engine saw a bus reset |
| long_reset_i | input | 1 | Qualifies `bus_reset_i`: the low pulse lasted at least 480 µs |
| dev_id_i | input | 64 | Device identity; family code in bits 7:0, CRC in bits 63:56 |
| rx_req_o | output | 1 | Requests one received bit |
| rx_ack_i | input | 1 | Received bit is valid |
| rx_bit_i | input | 1 | Received bit value |
| tx_req_o | output | 1 | Requests that `tx_bit_o` be sent in a slot |
| tx_bit_o | output | 1 | Bit to send |
| tx_ack_i | input | 1 | Send slot is complete |
| od_o | output | 1 | Overdrive flag for the slot engine |
| rc_o | output | 1 | Resume flag |
| func_o | output | 1 | The function layer owns the bus |
| func_go_o | output | 1 | One-cycle pulse when control is handed over |

## Verification
A bus reset and the completion of a command can land in the same clock cycle. When they do, the hand-over and the setting of the resume flag collide with the return to command reception.

The bench provokes this collision by raising `bus_reset_i` in the very cycle that acknowledges the 64th bit of a matching ID. It then judges the outcome at the ports: `func_go_o` and `func_o` must stay low, `rc_o` must stay clear, and `rx_req_o` must be high for a fresh command.

Alongside that, the bench sweeps every command code, every mismatch position in match, and every drop-out position in search.

// File: rtl/sw_rom_pkg.sv
`timescale 1ns/1ps
package sw_rom_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] OP_READ     = 8'h33;
  localparam logic [CMD_W-1:0] OP_MATCH    = 8'h55;
  localparam logic [CMD_W-1:0] OP_SEARCH   = 8'hF0;
  localparam logic [CMD_W-1:0] OP_SKIP     = 8'hCC;
  localparam logic [CMD_W-1:0] OP_RESUME   = 8'hA5;
  localparam logic [CMD_W-1:0] OP_OD_SKIP  = 8'h3C;
  localparam logic [CMD_W-1:0] OP_OD_MATCH = 8'h69;

  typedef enum logic [2:0] {
    CMD_READ, CMD_MATCH, CMD_SEARCH, CMD_SKIP,
    CMD_RESUME, CMD_OD_SKIP, CMD_OD_MATCH, CMD_BAD
  } rom_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_MATCH,
    ST_S_TRUE, ST_S_CMPL, ST_S_DIR, ST_FUNC
  } rom_st_e;
endpackage

// File: rtl/sw_rom_cmd_dec.sv
`timescale 1ns/1ps
module sw_rom_cmd_dec
  import sw_rom_pkg::*;
(
  input  logic [CMD_W-1:0] code_i,
  output rom_cmd_e         cmd_o
);
  always_comb begin
    unique case (code_i)
      OP_READ:     cmd_o = CMD_READ;
      OP_MATCH:    cmd_o = CMD_MATCH;
      OP_SEARCH:   cmd_o = CMD_SEARCH;
      OP_SKIP:     cmd_o = CMD_SKIP;
      OP_RESUME:   cmd_o = CMD_RESUME;
      OP_OD_SKIP:  cmd_o = CMD_OD_SKIP;
      OP_OD_MATCH: cmd_o = CMD_OD_MATCH;
      default:     cmd_o = CMD_BAD;
    endcase
  end
endmodule

// File: rtl/sw_rom_bit_ctr.sv
`timescale 1ns/1ps
module sw_rom_bit_ctr #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sw_rom_id_sel.sv
`timescale 1ns/1ps
module sw_rom_id_sel #(
  parameter int ID_W  = 64,
  localparam int IDX_W = $clog2(ID_W)
) (
  input  logic [ID_W-1:0]  id_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);
  assign bit_o = id_i[idx_i];
endmodule

// File: rtl/sw_rom_layer.sv
`timescale 1ns/1ps
module sw_rom_layer
  import sw_rom_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_reset_i,
  input  logic            long_reset_i,
  input  logic [ID_W-1:0] dev_id_i,
  output logic            rx_req_o,
  input  logic            rx_ack_i,
  input  logic            rx_bit_i,
  output logic            tx_req_o,
  output logic            tx_bit_o,
  input  logic            tx_ack_i,
  output logic            od_o,
  output logic            rc_o,
  output logic            func_o,
  output logic            func_go_o
);
  localparam int IDX_W = $clog2(ID_W);
  localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);
  localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_W - 1);

  rom_st_e          st_q, st_d;
  logic [CMD_W-2:0] cmd_q, cmd_d;
  logic [CMD_W-1:0] cmd_nxt;
  logic             od_d, rc_d, go_d;
  logic             cnt_clr, cnt_inc;
  logic [IDX_W-1:0] idx;
  logic             id_bit, rx_take, tx_take;
  rom_cmd_e         cmd_dec;

  sw_rom_bit_ctr #(.W(IDX_W)) u_ctr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (cnt_clr), .inc_i (cnt_inc), .cnt_o (idx)
  );

  sw_rom_id_sel #(.ID_W(ID_W)) u_sel (
    .id_i (dev_id_i), .idx_i (idx), .bit_o (id_bit)
  );

  // command bits arrive LSB first; shift in from the top
  assign cmd_nxt = {rx_bit_i, cmd_q};

  sw_rom_cmd_dec u_dec (.code_i (cmd_nxt), .cmd_o (cmd_dec));

  assign rx_req_o  = (st_q == ST_CMD) || (st_q == ST_MATCH) || (st_q == ST_S_DIR);
  assign tx_req_o  = (st_q == ST_READ) || (st_q == ST_S_TRUE) || (st_q == ST_S_CMPL);
  assign tx_bit_o  = (st_q == ST_S_CMPL) ? ~id_bit : id_bit;
  assign func_o    = (st_q == ST_FUNC);
  assign rx_take   = rx_req_o & rx_ack_i;
  assign tx_take   = tx_req_o & tx_ack_i;

  always_comb begin
    st_d    = st_q;
    cmd_d   = cmd_q;
    od_d    = od_o;
    rc_d    = rc_o;
    go_d    = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (st_q)
      ST_CMD: if (rx_take) begin
        cmd_d   = cmd_nxt[CMD_W-1:1];
        cnt_inc = 1'b1;
        if (idx == CMD_LAST) begin
          cnt_clr = 1'b1;
          unique case (cmd_dec)
            CMD_READ:     st_d = ST_READ;
            CMD_MATCH:    begin rc_d = 1'b0; st_d = ST_MATCH; end
            CMD_SEARCH:   begin rc_d = 1'b0; st_d = ST_S_TRUE; end
            CMD_SKIP:     begin go_d = 1'b1; st_d = ST_FUNC; end
            CMD_RESUME:   begin go_d = rc_o; st_d = rc_o ? ST_FUNC : ST_IDLE; end
            CMD_OD_SKIP:  begin od_d = 1'b1; go_d = 1'b1; st_d = ST_FUNC; end
            CMD_OD_MATCH: begin od_d = 1'b1; rc_d = 1'b0; st_d = ST_MATCH; end
            default:      st_d = ST_IDLE;
          endcase
        end
      end
      ST_READ: if (tx_take) begin
        cnt_inc = 1'b1;
        if (idx == ID_LAST) begin go_d = 1'b1; st_d = ST_FUNC; end
      end
      ST_MATCH, ST_S_DIR: if (rx_take) begin
        if (rx_bit_i != id_bit) st_d = ST_IDLE;
        else begin
          cnt_inc = 1'b1;
          if (idx == ID_LAST) begin
            rc_d = 1'b1; go_d = 1'b1; st_d = ST_FUNC;
          end else if (st_q == ST_S_DIR) st_d = ST_S_TRUE;
        end
      end
      ST_S_TRUE: if (tx_take) st_d = ST_S_CMPL;
      ST_S_CMPL: if (tx_take) st_d = ST_S_DIR;
      default: ;
    endcase
    // bus reset overrides whatever the current slot completed
    if (bus_reset_i) begin
      st_d    = ST_CMD;
      cmd_d   = '0;
      cnt_clr = 1'b1;
      go_d    = 1'b0;
      rc_d    = rc_o;
      od_d    = long_reset_i ? 1'b0 : od_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cmd_q     <= '0;
      od_o      <= 1'b0;
      rc_o      <= 1'b0;
      func_go_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      cmd_q     <= cmd_d;
      od_o      <= od_d;
      rc_o      <= rc_d;
      func_go_o <= go_d;
    end
  end

  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_req_o && tx_req_o)); // R2
  AST_RST_TO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (rx_req_o && !func_o)); // R1
  AST_LONG_RST_STD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_reset_i && long_reset_i) |=> !od_o); // R10
  AST_SHORT_RST_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_reset_i && !long_reset_i) |=> (od_o == $past(od_o))); // R10
  AST_RST_KEEP_RC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (rc_o == $past(rc_o))); // R10
  AST_RST_NO_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> !func_go_o); // R12
  AST_RC_ON_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rc_o) |-> func_go_o); // R4
  AST_GO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_go_o |-> (func_o && $rose(func_o))); // R13
  AST_GO_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_go_o |=> !func_go_o); // R13
endmodule

// File: tb/sw_rom_layer_tb_top.sv
`timescale 1ns/1ps
module sw_rom_layer_tb_top;
  localparam logic [63:0] ID = 64'hB4_9A3C5E7D1F20_47;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_reset_i = 1'b0, long_reset_i = 1'b0;
  logic rx_ack_i = 1'b0, rx_bit_i = 1'b0, tx_ack_i = 1'b0;
  logic rx_req_o, tx_req_o, tx_bit_o, od_o, rc_o, func_o, func_go_o;
  int   n_cmp = 0, n_bad = 0;
  logic go_seen;

  always #10 clk = ~clk;

  sw_rom_layer #(.ID_W(64)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .bus_reset_i (bus_reset_i), .long_reset_i (long_reset_i),
    .dev_id_i (ID), .rx_req_o (rx_req_o), .rx_ack_i (rx_ack_i), .rx_bit_i (rx_bit_i),
    .tx_req_o (tx_req_o), .tx_bit_o (tx_bit_o), .tx_ack_i (tx_ack_i),
    .od_o (od_o), .rc_o (rc_o), .func_o (func_o), .func_go_o (func_go_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_rst(input logic lng);
    @(negedge clk); bus_reset_i = 1'b1; long_reset_i = lng;
    @(negedge clk); bus_reset_i = 1'b0; long_reset_i = 1'b0;
  endtask

  task automatic put_bit(input logic b);
    int k = 0;
    while (!rx_req_o && k < 20) begin @(negedge clk); k++; end
    rx_ack_i = 1'b1; rx_bit_i = b;
    @(negedge clk); rx_ack_i = 1'b0;
    go_seen = func_go_o;
  endtask

  task automatic get_bit(output logic b);
    int k = 0;
    while (!tx_req_o && k < 20) begin @(negedge clk); k++; end
    b = tx_req_o ? tx_bit_o : 1'bx;
    tx_ack_i = 1'b1;
    @(negedge clk); tx_ack_i = 1'b0;
    go_seen = func_go_o;
  endtask

  task automatic send_byte(input logic [7:0] c);
    for (int i = 0; i < 8; i++) put_bit(c[i]);
  endtask

  task automatic expect_idle(input string tag);
    repeat (3) @(negedge clk);
    chk(tag, {61'd0, rx_req_o, tx_req_o, func_o}, 64'd0);
  endtask

  function automatic logic known(input logic [7:0] c);
    return c == 8'h33 || c == 8'h55 || c == 8'hF0 || c == 8'hCC ||
           c == 8'hA5 || c == 8'h3C || c == 8'h69;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {59'd0, rx_req_o, tx_req_o, od_o, rc_o, func_o}, 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle before bus reset", {62'd0, rx_req_o, tx_req_o}, 64'd0);
    bus_rst(1'b1);
    chk("R1 command request", {63'd0, rx_req_o}, 64'd1);

    // R3 read-ID
    begin
      logic [63:0] got; logic b;
      send_byte(8'h33);
      for (int i = 0; i < 64; i++) begin get_bit(b); got[i] = b; end
      chk("R3 read id value", got, ID);
      chk("R13 go pulse after read", {63'd0, go_seen}, 64'd1);
      @(negedge clk);
      chk("R13 go single, func held", {62'd0, func_go_o, func_o}, 64'd1);
    end

    // R7 resume with flag clear
    bus_rst(1'b1); send_byte(8'hA5);
    expect_idle("R7 resume without flag idles");

    // R4 exact match
    bus_rst(1'b1); send_byte(8'h55);
    for (int i = 0; i < 64; i++) put_bit(ID[i]);
    chk("R4 match go", {63'd0, go_seen}, 64'd1);
    chk("R4 match sets rc", {62'd0, rc_o, func_o}, 64'd3);

    bus_rst(1'b1);
    chk("R10 reset keeps rc", {63'd0, rc_o}, 64'd1);
    send_byte(8'hA5);
    chk("R7 resume with flag", {63'd0, go_seen}, 64'd1);

    bus_rst(1'b1); send_byte(8'hCC);
    chk("R6 skip go, rc and od kept", {61'd0, go_seen, rc_o, od_o}, 64'd6);

    // R4 mismatch at every position
    for (int p = 0; p < 64; p++) begin
      bus_rst(1'b0); send_byte(8'h55);
      for (int i = 0; i <= p; i++) put_bit(i == p ? ~ID[i] : ID[i]);
      expect_idle("R4 mismatch idles");
      chk("R4 rc cleared", {63'd0, rc_o}, 64'd0);
    end

    // R5 full search
    begin
      logic t, c; int bad = 0;
      bus_rst(1'b1); send_byte(8'hF0);
      for (int i = 0; i < 64; i++) begin
        get_bit(t); get_bit(c);
        if (t !== ID[i] || c !== ~ID[i]) bad++;
        put_bit(ID[i]);
      end
      chk("R5 search triplets", 64'(bad), 64'd0);
      chk("R5 search go and rc", {62'd0, go_seen, rc_o}, 64'd3);
    end

    // R5 drop-out at every position
    for (int p = 0; p < 64; p++) begin
      logic t, c;
      bus_rst(1'b0); send_byte(8'hF0);
      for (int i = 0; i <= p; i++) begin
        get_bit(t); get_bit(c);
        put_bit(i == p ? ~ID[i] : ID[i]);
      end
      expect_idle("R5 search drop idles");
      chk("R5 search clears rc", {63'd0, rc_o}, 64'd0);
    end

    // R8 overdrive-skip, R10 reset lengths
    bus_rst(1'b1); send_byte(8'h3C);
    chk("R8 od skip", {62'd0, go_seen, od_o}, 64'd3);
    bus_rst(1'b0);
    chk("R10 short reset keeps od", {63'd0, od_o}, 64'd1);
    bus_rst(1'b1);
    chk("R10 long reset clears od", {63'd0, od_o}, 64'd0);

    // R9 overdrive-match
    send_byte(8'h69);
    chk("R9 od set after command", {63'd0, od_o}, 64'd1);
    for (int i = 0; i < 64; i++) put_bit(ID[i]);
    chk("R9 od match go and rc", {61'd0, go_seen, rc_o, od_o}, 64'd7);
    bus_rst(1'b0); send_byte(8'h69);
    for (int i = 0; i < 6; i++) put_bit(i == 5 ? ~ID[i] : ID[i]);
    expect_idle("R9 od match mismatch idles");
    chk("R9 rc clear, od kept", {62'd0, rc_o, od_o}, 64'd1);

    // R11 all unknown codes
    for (int c = 0; c < 256; c++) begin
      if (!known(8'(c))) begin
        bus_rst(1'b1); send_byte(8'(c));
        expect_idle($sformatf("R11 code %02h idles", c));
      end
    end

    // R12 bus reset on the final match bit
    bus_rst(1'b1); send_byte(8'h55);
    for (int i = 0; i < 63; i++) put_bit(ID[i]);
    begin
      int k = 0;
      while (!rx_req_o && k < 20) begin @(negedge clk); k++; end
    end
    rx_ack_i = 1'b1; rx_bit_i = ID[63]; bus_reset_i = 1'b1; long_reset_i = 1'b0;
    @(negedge clk);
    rx_ack_i = 1'b0; bus_reset_i = 1'b0;
    chk("R12 reset wins", {60'd0, func_go_o, func_o, rc_o, rx_req_o}, 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule